// File: doc/BRIEF.md
# Multi-Waveform Lookup Table Generator

This block produces a periodic 8-bit unsigned sample stream for a digital-to-analog converter. It can produce a sine, square, triangle or sawtooth wave. Every waveform comes from one read-only table of 1024 entries. The table is split into four regions of 256 samples. The 2-bit waveform select supplies the upper two address bits, and an 8-bit phase counter supplies the lower eight bits. The table contents are computed at elaboration from fixed formulas, so no initialisation file is needed.

On each clock where enable is high, the phase counter advances by an integer step and wraps modulo 256. The output frequency is therefore f_clk × step / 256. For example, a step of 1 at 100 MHz gives 390.625 kHz. The table read is registered. The value read is then scaled by an 8-bit amplitude and registered a second time, so every result leaves the block two clocks after its address was formed. The phase counter is never reset by a waveform change, so switching waveform keeps the phase.

Top module: `wavegen_lut`

## Requirements
- R1: The table holds four regions of 256 entries, each entry 8 bits wide (levels 0..255). The table address is {wave_sel, phase}. wave_sel codes are 0 = sine, 1 = square, 2 = triangle, 3 = sawtooth.
- R2: Sine entry i is the integer part of (sin(2πi/256) + 1) × 127.5.
- R3: Square entry i is 255 when i < 128 and 0 when i ≥ 128.
- R4: Triangle entry i is floor(i × 255 / 128) when i < 128, and floor((256 − i) × 255 / 128) when i ≥ 128.
- R5: Sawtooth entry i is floor(i × 255 / 256).
- R6: On every clock with enable high, the phase advances by step, modulo 256. With enable low, the phase holds its value.
- R7: An address formed at clock edge k (from the phase and wave_sel present before that edge) produces its sample at edge k+1. sample_valid equals enable delayed by two clocks.
- R8: sample_out equals (table value × amplitude) >> 8. The amplitude used is the one present at the output edge. An amplitude of 0 gives 0, and the sample never exceeds the amplitude.
- R9: A change of wave_sel takes effect at the next table read and does not disturb the phase counter.
- R10: A synchronous active-high reset clears the phase to 0 and sets sample_out to 0 and sample_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advances the phase and marks the resulting samples valid |
| wave_sel | input | 2 | Waveform code: 0 sine, 1 square, 2 triangle, 3 sawtooth |
| step | input | 8 | Phase increment per enabled clock |
| amplitude | input | 8 | Output scale factor, applied as (value × amplitude) >> 8 |
| sample_out | output | 8 | Scaled unsigned sample |
| sample_valid | output | 1 | Sample qualifier, enable delayed by two clocks |

## Verification
Each result has its own delay from the inputs that cause it:
- A step or enable presented before an edge moves the phase at that edge.
- The table value at that phase, and the wave_sel presented at the same edge, appear at sample_out one edge later.
- The amplitude acts one edge after the read, at the output edge itself.
- sample_valid follows enable by two edges.

The bench drives inputs on the falling edge. After every rising edge it updates a small model that holds the same two-stage delay, and it compares outputs on the next falling edge, so each result is checked in the cycle it falls due. Table entries in the model come from the formulas in the requirements, not from the design.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

   typedef enum logic [1:0] {
      WAVE_SINE   = 2'd0,
      WAVE_SQUARE = 2'd1,
      WAVE_TRI    = 2'd2,
      WAVE_SAW    = 2'd3
   } wave_e;

   localparam real TWO_PI = 6.283185307179586;

   // Table entry for waveform `wave` at index `idx` in a table of `n` entries
   // with full-scale level `fs`.
   function automatic int table_entry(int wave, int idx, int n, int fs);
      real r;
      int  half;
      half = n / 2;
      case (wave)
         0: begin
            r = ($sin(TWO_PI * idx / n) + 1.0) * (fs / 2.0);
            if (r < 0.0) r = 0.0;
            return $rtoi(r);
         end
         1: return (idx < half) ? fs : 0;
         2: return (idx < half) ? (idx * fs) / half : ((n - idx) * fs) / half;
         default: return (idx * fs) / n;
      endcase
   endfunction

endpackage

// File: rtl/wg_phase.sv
module wg_phase #(
   parameter int PH_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [PH_W-1:0] step,
   output logic [PH_W-1:0] phase
);

   always_ff @(posedge clk) begin
      if (rst)     phase <= '0;
      else if (en) phase <= phase + step;
   end

endmodule

// File: rtl/wg_rom.sv
module wg_rom #(
   parameter int PH_W   = 8,
   parameter int SEL_W  = 2,
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [SEL_W+PH_W-1:0]  addr,
   input  logic                   rd_en,
   output logic [DATA_W-1:0]      q,
   output logic                   q_valid
);

   localparam int REGION = 1 << PH_W;
   localparam int WAVES  = 1 << SEL_W;
   localparam int DEPTH  = REGION * WAVES;
   localparam int FS     = (1 << DATA_W) - 1;

   logic [DATA_W-1:0] tbl [DEPTH];

   for (genvar w = 0; w < WAVES; w++) begin : g_wave
      for (genvar i = 0; i < REGION; i++) begin : g_entry
         localparam int VAL = wavegen_pkg::table_entry(w, i, REGION, FS);
         assign tbl[w*REGION + i] = DATA_W'(VAL);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q       <= '0;
         q_valid <= 1'b0;
      end else begin
         q       <= tbl[addr];
         q_valid <= rd_en;
      end
   end

endmodule

// File: rtl/wg_scale.sv
module wg_scale #(
   parameter int DATA_W = 8,
   parameter int AMP_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] d,
   input  logic              d_valid,
   input  logic [AMP_W-1:0]  amp,
   output logic [DATA_W-1:0] y,
   output logic              y_valid
);

   localparam int PROD_W = DATA_W + AMP_W;

   logic [PROD_W-1:0] prod;
   logic [DATA_W-1:0] scaled;

   always_comb begin
      prod   = PROD_W'(d) * PROD_W'(amp);
      scaled = DATA_W'(prod >> AMP_W);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         y       <= '0;
         y_valid <= 1'b0;
      end else begin
         y       <= scaled;
         y_valid <= d_valid;
      end
   end

endmodule

// File: rtl/wavegen_lut.sv
module wavegen_lut #(
   parameter int PH_W   = 8,
   parameter int SEL_W  = 2,
   parameter int DATA_W = 8,
   parameter int AMP_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic [SEL_W-1:0]  wave_sel,
   input  logic [PH_W-1:0]   step,
   input  logic [AMP_W-1:0]  amplitude,
   output logic [DATA_W-1:0] sample_out,
   output logic              sample_valid
);

   localparam int ADDR_W = SEL_W + PH_W;

   if (SEL_W != 2) begin : g_bad_sel
      $error("wavegen_lut: SEL_W must be 2 for four waveforms");
   end
   if (PH_W < 2 || PH_W > 12) begin : g_bad_ph
      $error("wavegen_lut: PH_W out of range 2..12");
   end
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_data
      $error("wavegen_lut: DATA_W out of range 2..16");
   end
   if (AMP_W < 1 || AMP_W > 16) begin : g_bad_amp
      $error("wavegen_lut: AMP_W out of range 1..16");
   end

   logic [PH_W-1:0]   phase_q;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rom_q;
   logic              rom_v;

   assign rd_addr = {wave_sel, phase_q};

   wg_phase #(.PH_W(PH_W)) u_phase (
      .clk   (clk),
      .rst   (rst),
      .en    (enable),
      .step  (step),
      .phase (phase_q)
   );

   wg_rom #(.PH_W(PH_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_rom (
      .clk     (clk),
      .rst     (rst),
      .addr    (rd_addr),
      .rd_en   (enable),
      .q       (rom_q),
      .q_valid (rom_v)
   );

   wg_scale #(.DATA_W(DATA_W), .AMP_W(AMP_W)) u_scale (
      .clk     (clk),
      .rst     (rst),
      .d       (rom_q),
      .d_valid (rom_v),
      .amp     (amplitude),
      .y       (sample_out),
      .y_valid (sample_valid)
   );

endmodule

// File: rtl/wavegen_lut_chk.sv
module wavegen_lut_chk #(
   parameter int PH_W   = 8,
   parameter int DATA_W = 8,
   parameter int AMP_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              enable,
   input logic [PH_W-1:0]   step,
   input logic [AMP_W-1:0]  amplitude,
   input logic [DATA_W-1:0] sample_out,
   input logic              sample_valid,
   input logic [PH_W-1:0]   phase
);

   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (phase == '0 && !sample_valid && sample_out == '0));

   assert_phase_step_R6: assert property (@(posedge clk) disable iff (rst)
      enable |=> phase == PH_W'($past(phase) + $past(step)));

   assert_phase_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !enable |=> $stable(phase));

   assert_valid_lag_R7: assert property (@(posedge clk) disable iff (rst)
      enable |-> ##2 sample_valid);

   assert_invalid_lag_R7: assert property (@(posedge clk) disable iff (rst)
      !enable |-> ##2 !sample_valid);

   assert_zero_amp_R8: assert property (@(posedge clk) disable iff (rst)
      (amplitude == '0) |=> (sample_out == '0));

   assert_bounded_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ({{AMP_W{1'b0}}, sample_out} <= {{DATA_W{1'b0}}, $past(amplitude)}));

endmodule

bind wavegen_lut wavegen_lut_chk #(
   .PH_W   (PH_W),
   .DATA_W (DATA_W),
   .AMP_W  (AMP_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .enable       (enable),
   .step         (step),
   .amplitude    (amplitude),
   .sample_out   (sample_out),
   .sample_valid (sample_valid),
   .phase        (phase_q)
);

// File: tb/wavegen_lut_test.sv
module wavegen_lut_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam int NVEC       = 8;

   // vector: {en[24], sel[23:22], step[21:14], amp[13:6], cycles[5:0]} (cycles 1..63)
   localparam logic [24:0] VEC [NVEC] = '{
      {1'b1, 2'd0, 8'd1,   8'd255, 6'd40},
      {1'b1, 2'd1, 8'd1,   8'd255, 6'd63},
      {1'b1, 2'd2, 8'd3,   8'd200, 6'd50},
      {1'b1, 2'd3, 8'd5,   8'd255, 6'd55},
      {1'b0, 2'd3, 8'd5,   8'd255, 6'd6},
      {1'b1, 2'd0, 8'd200, 8'd128, 6'd30},
      {1'b1, 2'd2, 8'd7,   8'd0,   6'd10},
      {1'b1, 2'd1, 8'd0,   8'd255, 6'd8}
   };
   localparam string VREQ [NVEC] = '{"R2", "R3", "R4", "R5", "R6", "R6", "R8", "R1"};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       enable = 1'b0;
   logic [1:0] wave_sel = '0;
   logic [7:0] step = '0;
   logic [7:0] amplitude = '0;
   logic [7:0] sample_out;
   logic       sample_valid;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // reference state
   int m_phase, m_rom, m_v1, m_out, m_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   wavegen_lut uut (
      .clk          (clk),
      .rst          (rst),
      .enable       (enable),
      .wave_sel     (wave_sel),
      .step         (step),
      .amplitude    (amplitude),
      .sample_out   (sample_out),
      .sample_valid (sample_valid)
   );

   function automatic int ref_entry(int w, int i);
      real s;
      if (w == 0) begin
         s = ($sin(6.283185307179586 * i / 256) + 1.0) * (255 / 2.0);
         if (s < 0.0) s = 0.0;
         return $rtoi(s);
      end
      if (w == 1) return (i < 128) ? 255 : 0;
      if (w == 2) return (i < 128) ? (i * 255) / 128 : ((256 - i) * 255) / 128;
      return (i * 255) / 256;
   endfunction

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_phase = 0; m_rom = 0; m_v1 = 0; m_out = 0; m_valid = 0;
   endtask

   // one clock: drive at negedge (caller), advance model at posedge, check at next negedge
   task automatic cycle(string req);
      @(posedge clk);
      if (rst) model_reset();
      else begin
         m_out   = (m_rom * int'(amplitude)) >> 8;
         m_valid = m_v1;
         m_rom   = ref_entry(int'(wave_sel), m_phase);
         m_v1    = int'(enable);
         if (enable) m_phase = (m_phase + int'(step)) % 256;
      end
      @(negedge clk);
      check(req, int'(sample_out), m_out, "sample_out");
      check(req, int'(sample_valid), m_valid, "sample_valid");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; enable = 1'b0;
      cycle("R10");
      cycle("R10");
      rst = 1'b0;
   endtask

   initial begin
      do_reset();
      check("R10", int'(sample_out), 0, "reset sample");
      check("R10", int'(sample_valid), 0, "reset valid");

      // table-driven runs
      for (int v = 0; v < NVEC; v++) begin
         enable    = VEC[v][24];
         wave_sel  = VEC[v][23:22];
         step      = VEC[v][21:14];
         amplitude = VEC[v][13:6];
         for (int c = 0; c < int'(VEC[v][5:0]); c++) cycle(VREQ[v]);
      end

      // R3: square boundary at index 127/128, full amplitude
      do_reset();
      enable = 1'b1; wave_sel = 2'd1; step = 8'd127; amplitude = 8'd255;
      cycle("R3");
      step = 8'd1;
      for (int c = 0; c < 4; c++) cycle("R3");

      // R9: toggle waveform each clock, phase continues
      for (int c = 0; c < 24; c++) begin
         wave_sel = 2'(c % 4);
         step = 8'd9;
         cycle("R9");
      end

      // R7: enable gaps, valid lag
      for (int c = 0; c < 12; c++) begin
         enable = (c % 3) != 0;
         cycle("R7");
      end

      // R10: reset mid-run restarts phase; sine index 0 at full scale -> 126
      do_reset();
      enable = 1'b1; wave_sel = 2'd0; step = 8'd0; amplitude = 8'd255;
      cycle("R10");
      cycle("R10");
      check("R10", int'(sample_out), 126, "sine[0] after reset");
      check("R7", int'(sample_valid), 1, "valid two clocks after enable");

      // R2: sine peak at index 64 -> 255*255>>8 = 254
      step = 8'd64;
      cycle("R2");
      step = 8'd0;
      cycle("R2");
      cycle("R2");
      check("R2", int'(sample_out), 254, "sine peak");

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < WATCHDOG; t++) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule